// File: doc/BRIEF.md
# Dual-Mode Source Router and Pair Deserializer

This block sits at the front of a two-channel symbol transmitter. It accepts either two independent serial bit streams, each at the channel bit rate, or one serial stream at twice that rate. It turns whichever it is given into two channel streams, A and B. Each channel stream is then gathered into parallel words of `WORD_BITS` bits, two bits by default, at half the channel bit rate. The result is four half-rate lanes, one 2-bit pair per channel, and all four update together once per word period.

One master clock runs at the fastest bit rate, so one cycle is one double-rate bit slot. An internal phase counter, cleared by reset, divides this clock into channel-bit slots of two cycles and word periods of `2*WORD_BITS` cycles. In dual mode a channel bit is held on its input for two cycles and is sampled in the second of them. In single mode each cycle carries one bit, and consecutive bits are dealt alternately to the two channels. The mode is read at the start of each word period and held until that word is complete.

Top module: `src_router_deser`

## Requirements
- R1: While `rst_ni` is low, both lane outputs read zero and `word_vld_o` is low.
- R2: With `mode_i`=0 (dual), the channel-A word holds the bits of `src_a_i` from the two 2-cycle slots of the word period, and the earlier bit is in the MSB (bit 1).
- R3: With `mode_i`=0 (dual), the channel-B word is built from `src_b_i` in the same way, with the earlier bit in the MSB.
- R4: With `mode_i`=1 (single), the bits on `src_fast_i` in cycles 0,1,2,3 of a word period go to A-MSB, B-MSB, A-LSB and B-LSB in that order. The first cycle after reset is cycle 0, so the first bit after reset goes to channel A.
- R5: `word_vld_o` is high for exactly one cycle in every `2*WORD_BITS` cycles, first in the cycle after the fourth rising edge following reset release. The lanes change only in a cycle where `word_vld_o` is high, and both lanes change together.
- R6: `mode_i` is sampled only in cycle 0 of a word period. A change later in the period takes effect at the next word.
- R7: In dual mode `src_fast_i` has no effect on the lanes. In single mode `src_a_i` and `src_b_i` have no effect on the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock at the double-rate bit slot |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = two independent sources, 1 = one double-rate source |
| src_fast_i | input | 1 | Double-rate serial input used in single mode |
| src_a_i | input | 1 | Channel-A serial input used in dual mode |
| src_b_i | input | 1 | Channel-B serial input used in dual mode |
| lane_a_o | output | WORD_BITS | Channel-A parallel word, earliest bit in the MSB |
| lane_b_o | output | WORD_BITS | Channel-B parallel word, earliest bit in the MSB |
| word_vld_o | output | 1 | One-cycle strobe marking new words on both lanes |

## Verification
The assertions take for granted that the clock runs freely after reset and that nothing but reset moves the phase counter. The strobe spacing and the lane-hold rules are therefore checked against a cycle count kept since reset. The stimulus releases reset on a falling edge and applies each bit for a whole word period aligned to that release, and dual-mode bits are held for two full cycles. Mode flips are placed only in the later half of a period, and the input that is not in use is driven with random values throughout.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  typedef enum logic {
    MODE_DUAL   = 1'b0,
    MODE_SINGLE = 1'b1
  } src_mode_e;
endpackage

// File: rtl/rtr_phase.sv
module rtr_phase #(
  parameter int PHASES = 4,
  localparam int PH_W  = $clog2(PHASES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] ph_o,
  output logic            first_o,
  output logic            last_o
);
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (last_o) ph_q <= '0;
    else             ph_q <= ph_q + 1'b1;
  end

  assign ph_o    = ph_q;
  assign first_o = (ph_q == '0);
  assign last_o  = (ph_q == PH_W'(PHASES-1));
endmodule

// File: rtl/rtr_route.sv
module rtr_route
  import rtr_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  src_mode_e       mode_i,
  input  logic [PH_W-1:0] ph_i,
  input  logic            src_fast_i,
  input  logic            src_a_i,
  input  logic            src_b_i,
  output logic [1:0]      take_o,
  output logic [1:0]      bit_o
);
  always_comb begin
    take_o = '0;
    bit_o  = '0;
    if (mode_i == MODE_SINGLE) begin
      // even slot feeds A, odd slot feeds B
      take_o[ph_i[0]] = 1'b1;
      bit_o[ph_i[0]]  = src_fast_i;
    end else if (ph_i[0]) begin
      // dual bits are sampled in the second cycle of their slot
      take_o = 2'b11;
      bit_o  = {src_b_i, src_a_i};
    end
  end
endmodule

// File: rtl/rtr_pair.sv
module rtr_pair #(
  parameter int WORD_BITS = 2,
  localparam int IDX_W    = $clog2(2*WORD_BITS) - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 take_i,
  input  logic                 bit_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [WORD_BITS-1:0] word_o
);
  logic [WORD_BITS-1:0] bits_q;
  logic [IDX_W-1:0]     pos;

  // first bit of the word lands in the MSB
  assign pos = IDX_W'(WORD_BITS-1) - idx_i;

  always_comb begin
    word_o = bits_q;
    if (take_i) word_o[pos] = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= word_o;
  end
endmodule

// File: rtl/src_router_deser.sv
module src_router_deser
  import rtr_pkg::*;
#(
  parameter int WORD_BITS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_i,
  input  logic                 src_fast_i,
  input  logic                 src_a_i,
  input  logic                 src_b_i,
  output logic [WORD_BITS-1:0] lane_a_o,
  output logic [WORD_BITS-1:0] lane_b_o,
  output logic                 word_vld_o
);
  localparam int PHASES = 2 * WORD_BITS;
  localparam int PH_W   = $clog2(PHASES);
  localparam int IDX_W  = PH_W - 1;

  logic [PH_W-1:0] ph;
  logic            ph_first, ph_last;
  src_mode_e       mode_q, mode_eff;
  logic [1:0]      take, bits;
  logic [WORD_BITS-1:0] word [2];
  logic [WORD_BITS-1:0] lane_q [2];
  logic            vld_q;

  rtr_phase #(.PHASES(PHASES)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ph_o    (ph),
    .first_o (ph_first),
    .last_o  (ph_last)
  );

  // mode is captured at the word boundary and held for the word
  assign mode_eff = ph_first ? src_mode_e'(mode_i) : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_DUAL;
    else         mode_q <= mode_eff;
  end

  rtr_route #(.PH_W(PH_W)) u_route (
    .mode_i     (mode_eff),
    .ph_i       (ph),
    .src_fast_i (src_fast_i),
    .src_a_i    (src_a_i),
    .src_b_i    (src_b_i),
    .take_o     (take),
    .bit_o      (bits)
  );

  for (genvar c = 0; c < 2; c++) begin : g_ch
    rtr_pair #(.WORD_BITS(WORD_BITS)) u_pair (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .take_i (take[c]),
      .bit_i  (bits[c]),
      .idx_i  (ph[PH_W-1 -: IDX_W]),
      .word_o (word[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lane_q[c] <= '0;
      else if (ph_last) lane_q[c] <= word[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= ph_last;
  end

  assign lane_a_o   = lane_q[0];
  assign lane_b_o   = lane_q[1];
  assign word_vld_o = vld_q;
endmodule

// File: rtl/rtr_chk.sv
module rtr_chk #(
  parameter int WORD_BITS = 2,
  localparam int PHASES   = 2 * WORD_BITS,
  localparam int GAP_W    = $clog2(PHASES) + 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [WORD_BITS-1:0] lane_a_o,
  input logic [WORD_BITS-1:0] lane_b_o,
  input logic                 word_vld_o
);
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gap_q <= '0;
    else if (word_vld_o) gap_q <= GAP_W'(1);
    else                 gap_q <= gap_q + 1'b1;
  end

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (lane_a_o == '0 && lane_b_o == '0 && !word_vld_o));

  assert_strobe_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o == (gap_q == GAP_W'(PHASES)));

  assert_strobe_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

  assert_lanes_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_o |-> ($stable(lane_a_o) && $stable(lane_b_o)));
endmodule

bind src_router_deser rtr_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lane_a_o   (lane_a_o),
  .lane_b_o   (lane_b_o),
  .word_vld_o (word_vld_o)
);

// File: tb/tb_src_router_deser.sv
module tb_src_router_deser;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0;
  logic       src_fast_i = 1'b0;
  logic       src_a_i = 1'b0;
  logic       src_b_i = 1'b0;
  logic [1:0] lane_a_o, lane_b_o;
  logic       word_vld_o;

  int errors = 0;
  int checks = 0;
  logic [1:0] exp_a = '0, exp_b = '0;

  src_router_deser #(.WORD_BITS(2)) dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // m=1: single source, bits f[0..3] in cycle order; m=0: a[k], b[k] for slot k
  function automatic logic [3:0] model(input logic m, input logic [3:0] f,
                                       input logic [1:0] a, input logic [1:0] b);
    if (m) return {f[0], f[2], f[1], f[3]};
    return {a[0], a[1], b[0], b[1]};
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    check("R1 lane_a", {2'b0, lane_a_o}, 4'd0);
    check("R1 lane_b", {2'b0, lane_b_o}, 4'd0);
    check("R1 vld", {3'b0, word_vld_o}, 4'd0);
    rst_ni = 1'b1;
    exp_a = '0; exp_b = '0;
  endtask

  task automatic run_word(input logic m, input logic flip, input logic [3:0] f,
                          input logic [1:0] a, input logic [1:0] b);
    logic [3:0] e;
    string ta, tb;
    for (int c = 0; c < 4; c++) begin
      mode_i     = (flip && c >= 2) ? ~m : m;
      src_fast_i = f[c];
      src_a_i    = a[c/2];
      src_b_i    = b[c/2];
      @(posedge clk_i); @(negedge clk_i);
      if (c < 3) begin
        check("R5 no strobe mid-word", {3'b0, word_vld_o}, 4'd0);
        check("R5 lanes held", {lane_a_o, lane_b_o}, {exp_a, exp_b});
      end
    end
    e = model(m, f, a, b);
    exp_a = e[3:2]; exp_b = e[1:0];
    ta = m ? "R4 R7 lane_a" : "R2 R7 lane_a";
    tb = m ? "R4 R7 lane_b" : "R3 R7 lane_b";
    if (flip) begin ta = {ta, " R6"}; tb = {tb, " R6"}; end
    check(ta, {2'b0, lane_a_o}, {2'b0, exp_a});
    check(tb, {2'b0, lane_b_o}, {2'b0, exp_b});
    check("R5 strobe", {3'b0, word_vld_o}, 4'd1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    do_reset();
    // R4: first bit after reset goes to channel A MSB
    run_word(1'b1, 1'b0, 4'b0001, 2'b11, 2'b11);
    run_word(1'b0, 1'b0, 4'b1111, 2'b01, 2'b10);
    run_word(1'b0, 1'b1, 4'b1010, 2'b10, 2'b01);
    run_word(1'b1, 1'b1, 4'b0110, 2'b00, 2'b11);
    for (int w = 0; w < 400; w++) begin
      logic [3:0] f;
      logic [1:0] a, b;
      f = 4'($urandom);
      a = 2'($urandom);
      b = 2'($urandom);
      run_word(1'($urandom), ($urandom % 5) == 0, f, a, b);
      if (w == 200) begin
        do_reset();
        run_word(1'b1, 1'b0, 4'b0101, 2'b10, 2'b10);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule